// File: doc/BRIEF.md
# Freezable Event Counter Bank

A bank of 32-bit event counters sitting beside a processor core's performance-monitoring logic. Each counter advances by one on every clock cycle in which its own event input is high, unless counting is frozen. Software reaches the counters and a single control register through a small indexed register port. It reads and writes individual counters, and it configures the freeze and alert behaviour through the control word.

Counting can be stopped in four ways. A global freeze bit stops everything. Three mode-freeze bits each stop counting while the core runs at one privilege level. An optional freeze-on-alert also stops counting. A counter counts as overflowed as soon as its most significant bit is 1, so software preloads 0x80000000 minus N to get an alert after N events. An alert sets a sticky flag in the control word. While alerts are enabled, that flag drives a level interrupt request. Two condition-enable bits choose which counters may raise the alert: one covers counter 1 and the other covers all the rest.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous reset, every counter is 0, the read data is 0, the interrupt request is low, and the control word is 0x001 (only the global freeze set).
- R2: Register index 0 selects the control word. Indices 1 to 8 select counters 1 to 8. Any other index reads as zero, and a write to it changes no counter and not the control word. Read data is registered: it shows the selected register's value at the clock edge that ends the read cycle.
- R3: An unfrozen counter whose event input is high adds 1 per clock edge, wrapping from 0xFFFFFFFF to 0.
- R4: Control bit 0 (global freeze) stops every counter from the first edge after the control write that sets it.
- R5: The cpu_mode input encodes 0 = user, 1 = supervisor, 2 = hypervisor, 3 = none. Control bits 1, 2 and 3 stop counting while the mode is user, supervisor or hypervisor respectively. Mode 3 is never mode-frozen.
- R6: A counter write in the same cycle as an event takes priority: the counter takes the written value.
- R7: When control bit 4 (alert enable) is set and an eligible counter has bit 31 set, control bit 8 (alert flag) is set at the next edge. The condition is re-evaluated every cycle, so the flag stays set while it persists.
- R8: Control bit 6 makes counter 1 eligible for alerts. Control bit 7 makes counters 2 to 8 eligible. With an eligibility bit clear, the counters it covers raise no alert.
- R9: With control bit 5 (freeze on alert) also set, the alert sets the global freeze in the same edge as the flag, and no counter advances while the alert condition holds. A counter reaching 0x80000000 therefore stops there.
- R10: The interrupt request is high exactly when the alert flag and alert enable are both set.
- R11: Writing the control word with the alert flag and global freeze clear, once no eligible counter has bit 31 set, drops the interrupt request and resumes counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index (0 = control, 1..8 = counters) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt | input | 8 | Per-counter event inputs, bit i feeds counter i+1 |
| cpu_mode | input | 2 | Current privilege mode of the core |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are stable and defined whenever `reg_we` is high. They also assume that `cpu_mode` changes only between clock edges. The stimulus meets both assumptions by driving every input on the falling clock edge and sampling results on the following falling edge. The write-priority and hold properties further assume that the event lines are driven to known values at all times. The bench therefore keeps `evt` at zero outside the windows in which it counts events on purpose.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CTL_W    = 9;
  localparam int B_GFRZ   = 0;
  localparam int B_FZUSR  = 1;
  localparam int B_FZSUP  = 2;
  localparam int B_FZHYP  = 3;
  localparam int B_AEN    = 4;
  localparam int B_FOA    = 5;
  localparam int B_CE1    = 6;
  localparam int B_CEN    = 7;
  localparam int B_FLAG   = 8;
  localparam logic [CTL_W-1:0] CTL_RESET = 9'h001;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_HYP  = 2'd2,
    MODE_NONE = 2'd3
  } cpu_mode_e;
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (inc)   cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R6: software write wins over an event
  a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_o == $past(wr_data));
  // R3: one step per enabled event, modulo 2^W
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && inc) |=> cnt_o == $past(cnt_o) + W'(1));
  // R4: no write and no event leaves the count alone
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !inc) |=> $stable(cnt_o));
endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             ovf_first,
  input  logic             ovf_rest,
  output logic [CTL_W-1:0] ctl_o,
  output logic             alert_hold_o,
  output logic             irq_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             alert_cond;

  assign alert_cond = ctl_q[B_AEN] &
                      ((ctl_q[B_CE1] & ovf_first) | (ctl_q[B_CEN] & ovf_rest));

  always_comb begin
    ctl_d = wr_en ? wr_data : ctl_q;
    if (alert_cond) begin
      ctl_d[B_FLAG] = 1'b1;
      if (ctl_q[B_FOA]) ctl_d[B_GFRZ] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= CTL_RESET;
    else     ctl_q <= ctl_d;
  end

  assign ctl_o        = ctl_q;
  assign alert_hold_o = alert_cond & ctl_q[B_FOA];
  assign irq_o        = ctl_q[B_FLAG] & ctl_q[B_AEN];

  // R7: an eligible overflow with alerts enabled sets the flag
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[B_AEN] && ctl_q[B_CE1] && ovf_first) |=> ctl_o[B_FLAG]);
  // R8: counters 2..N raise the flag only through their own enable
  a_r8_rest_sets: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[B_AEN] && ctl_q[B_CEN] && ovf_rest) |=> ctl_o[B_FLAG]);
  // R9: freeze-on-alert sets the global freeze with the flag
  a_r9_freeze_on_alert: assert property (@(posedge clk) disable iff (rst)
    (alert_cond && ctl_q[B_FOA]) |=> (ctl_o[B_GFRZ] && ctl_o[B_FLAG]));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CTR_W-1:0]   reg_wdata,
  output logic [CTR_W-1:0]   reg_rdata,
  input  logic [NUM_CTR-1:0] evt,
  input  logic [1:0]         cpu_mode,
  output logic               irq
);
  localparam int FLAT_W = NUM_CTR * CTR_W;

  logic [FLAT_W-1:0]  cnt_flat;
  logic [NUM_CTR-1:0] msb;
  logic [CTL_W-1:0]   ctl;
  logic               alert_hold, mode_frz, frozen, ovf_rest, ctl_we;
  logic [CTR_W-1:0]   rd_mux;

  assign ctl_we = reg_we && (reg_addr == '0);

  always_comb begin
    case (cpu_mode_e'(cpu_mode))
      MODE_USER: mode_frz = ctl[B_FZUSR];
      MODE_SUP:  mode_frz = ctl[B_FZSUP];
      MODE_HYP:  mode_frz = ctl[B_FZHYP];
      default:   mode_frz = 1'b0;
    endcase
  end

  assign frozen = ctl[B_GFRZ] | mode_frz | alert_hold;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic wr_i;
    assign wr_i = reg_we && (reg_addr == ADDR_W'(i + 1));
    evc_counter #(.W(CTR_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_i),
      .wr_data (reg_wdata),
      .inc     (evt[i] & ~frozen),
      .cnt_o   (cnt_flat[i*CTR_W +: CTR_W])
    );
    assign msb[i] = cnt_flat[i*CTR_W + CTR_W - 1];
  end

  if (NUM_CTR > 1) begin : g_rest
    assign ovf_rest = |msb[NUM_CTR-1:1];
  end else begin : g_single
    assign ovf_rest = 1'b0;
  end

  evc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (ctl_we),
    .wr_data      (reg_wdata[CTL_W-1:0]),
    .ovf_first    (msb[0]),
    .ovf_rest     (ovf_rest),
    .ctl_o        (ctl),
    .alert_hold_o (alert_hold),
    .irq_o        (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == '0) rd_mux = CTR_W'(ctl);
    for (int i = 0; i < NUM_CTR; i++)
      if (reg_addr == ADDR_W'(i + 1)) rd_mux = cnt_flat[i*CTR_W +: CTR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R2: unmapped indices read as zero
  a_r2_bad_index: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > ADDR_W'(NUM_CTR)) |=> reg_rdata == '0);
  // R4: with the global freeze set and no write, the whole bank holds
  a_r4_global_freeze: assert property (@(posedge clk) disable iff (rst)
    (ctl[B_GFRZ] && !reg_we) |=> $stable(cnt_flat));
  // R10: no request without alert enable
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !ctl[B_AEN] |-> !irq);
endmodule

// File: tb/evc_bank_test.sv
module evc_bank_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  evt;
  logic [1:0]  cpu_mode;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  evc_bank uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .cpu_mode(cpu_mode), .irq(irq)
  );

  // {ctrl[8:0], mode[1:0], event on, cycles[7:0], expected count[7:0]}
  localparam logic [27:0] VEC [0:8] = '{
    {9'h000, 2'd0, 1'b1, 8'd5, 8'd5},
    {9'h001, 2'd0, 1'b1, 8'd5, 8'd0},
    {9'h002, 2'd0, 1'b1, 8'd5, 8'd0},
    {9'h002, 2'd1, 1'b1, 8'd5, 8'd5},
    {9'h004, 2'd1, 1'b1, 8'd4, 8'd0},
    {9'h008, 2'd2, 1'b1, 8'd6, 8'd0},
    {9'h008, 2'd1, 1'b1, 8'd7, 8'd7},
    {9'h000, 2'd3, 1'b1, 8'd3, 8'd3},
    {9'h000, 2'd0, 1'b0, 8'd6, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_ev(input logic [7:0] m, input int n);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt = '0; cpu_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'd0, v); chk("R1 ctrl", v, 32'h001);
    rd(4'd1, v); chk("R1 ctr1", v, 32'h0);
    rd(4'd8, v); chk("R1 ctr8", v, 32'h0);

    // R3 R4 R5: table walk on counter 1
    for (int k = 0; k < 9; k++) begin
      wr(4'd0, 32'h001);
      wr(4'd1, 32'h0);
      cpu_mode = VEC[k][18:17];
      wr(4'd0, {23'b0, VEC[k][27:19]});
      run_ev({7'b0, VEC[k][16]}, int'(VEC[k][15:8]));
      wr(4'd0, 32'h001);
      rd(4'd1, v);
      chk("R3/R4/R5 table", v, {24'b0, VEC[k][7:0]});
    end
    cpu_mode = 2'd3;

    // R6: write beats a concurrent event
    wr(4'd0, 32'h000);
    evt = 8'h02;
    wr(4'd2, 32'd100);
    wr(4'd0, 32'h001);
    evt = '0;
    rd(4'd2, v); chk("R6 write priority", v, 32'd101);

    // R3: wrap
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd0, 32'h000);
    run_ev(8'h04, 1);
    wr(4'd0, 32'h001);
    rd(4'd3, v); chk("R3 wrap", v, 32'h0);

    // R7 R9 R10: alert with freeze on counter 1
    wr(4'd1, 32'h7FFF_FFFE);
    wr(4'd0, 32'h070);
    run_ev(8'h01, 5);
    rd(4'd1, v); chk("R9 stop at 0x80000000", v, 32'h8000_0000);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    rd(4'd0, v); chk("R7/R9 ctrl after alert", v, 32'h171);

    // R11: re-arm
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h070);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);
    run_ev(8'h01, 3);
    rd(4'd1, v); chk("R11 counting resumed", v, 32'd3);

    // R2: unmapped indices
    wr(4'd0, 32'h001);
    wr(4'd9, 32'hDEAD_BEEF);
    wr(4'd15, 32'h0000_00FF);
    rd(4'd9, v);  chk("R2 index 9 reads zero", v, 32'h0);
    rd(4'd15, v); chk("R2 index 15 reads zero", v, 32'h0);
    rd(4'd1, v);  chk("R2 ctr1 untouched", v, 32'd3);
    rd(4'd0, v);  chk("R2 ctrl untouched", v, 32'h001);
    wr(4'd8, 32'hA5A5_0F0F);
    rd(4'd8, v);  chk("R2 ctr8 write/read", v, 32'hA5A5_0F0F);

    // R8: eligibility of counters 2..8
    wr(4'd2, 32'h8000_0000);
    wr(4'd0, 32'h050);
    repeat (3) @(negedge clk);
    chk("R8 no alert without rest enable", {31'b0, irq}, 32'h0);
    rd(4'd0, v); chk("R8 ctrl unchanged", v, 32'h050);
    wr(4'd0, 32'h090);
    @(negedge clk);
    chk("R8/R10 irq via rest enable", {31'b0, irq}, 32'h1);
    rd(4'd0, v); chk("R7 flag without freeze", v, 32'h190);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule